// File: doc/BRIEF.md
# Return-from-Interrupt State Restorer

This block computes the machine state and the resume address that take effect when an interrupt handler returns. It takes three 64-bit words: the machine state as it stands now, the state word saved at interrupt entry, and the program counter saved at interrupt entry. From these it builds the restored machine state and the address of the next instruction. Most bits of the restored state come straight from the saved word. A small set of bits keeps its current value. A 3-bit transactional field changes only under a guarded rule. Three enable bits, for external interrupts, instruction translation and data translation, are forced on whenever the restored word selects problem (user) state.

Bit positions below use MSB-first numbering: position p is vector bit 63-p. A pulse on `start_i` captures the inputs. One cycle later `done_o` pulses, and the registered state and address appear with it. Both then hold until the next capture.

Top module: `rfi_restorer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `done_o` is 0 and `new_state_o` and `next_pc_o` are all zeros.
- R2: `done_o` is 1 in exactly the cycles that follow a cycle with `start_i` high. If `start_i` stays high for consecutive cycles, the results follow back to back.
- R3: After a cycle without `start_i`, `new_state_o` and `next_pc_o` do not change, whatever the inputs do.
- R4: `next_pc_o` equals the saved PC with vector bits [1:0] cleared.
- R5: The transactional field is positions 29..31, which is vector bits [34:32] with position 29 as its MSB. If the current field is 3'b010 and the saved field is 3'b000, the restored field is 3'b010. In every other case the restored field takes the saved field.
- R6: Restored positions 48, 58 and 59 (vector bits 15, 5 and 4) each equal the saved bit at that position ORed with saved position 49 (vector bit 14), the problem-state bit.
- R7: Restored positions 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 equal the saved word at the same positions.
- R8: Restored positions 3, 33..36, 42..47 and 51 equal the current machine state at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture strobe for the three input words |
| cur_state_i | input | 64 | Machine state before the return |
| saved_state_i | input | 64 | State word saved at interrupt entry |
| saved_pc_i | input | 64 | Program counter saved at interrupt entry |
| done_o | output | 1 | Pulses one cycle after a capture |
| new_state_o | output | 64 | Restored machine state |
| next_pc_o | output | 64 | Word-aligned resume address |

## Verification
The bench sweeps all 64 pairings of current and saved transactional fields. A design that inverts or narrows the guard would let the saved zero field overwrite the held 3'b010 pattern, or would hold the current field when it should be replaced. It also sweeps all 16 combinations of the saved problem-state bit and the three enables. A design that misses the OR, or that keys it on the wrong bit, leaves an enable clear in problem state. Random words with random low address bits expose copy and keep masks that are off by one position, and a missing address alignment. Inputs are changed between captures, and back-to-back strobes are issued, to catch outputs that are not held or a done pulse that is late or stretched.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    localparam int XLEN       = 64;
    localparam int TXN_FIRST  = 29;
    localparam int TXN_LAST   = 31;
    localparam int TXN_W      = TXN_LAST - TXN_FIRST + 1;
    localparam int PROB_POS   = 49;
    localparam int N_FORCED   = 3;

    // guard pattern: current field and saved field that leave the field untouched
    localparam logic [TXN_W-1:0] TXN_HOLD_CUR   = 3'b010;
    localparam logic [TXN_W-1:0] TXN_HOLD_SAVED = 3'b000;

    typedef enum logic [1:0] {
        SRC_SAVED   = 2'd0,
        SRC_CURRENT = 2'd1,
        SRC_TXN     = 2'd2,
        SRC_FORCED  = 2'd3
    } bit_src_e;

    typedef struct packed {
        logic [XLEN-1:0] cur_state;
        logic [XLEN-1:0] saved_state;
        logic [XLEN-1:0] saved_pc;
    } rfi_in_t;

    typedef struct packed {
        logic [XLEN-1:0] state;
        logic [XLEN-1:0] pc;
    } rfi_out_t;

    // MSB-first position to vector index
    function automatic int lsb_idx(input int pos);
        return XLEN - 1 - pos;
    endfunction

    // positions of the enables that problem state forces on
    function automatic int forced_pos(input int slot);
        case (slot)
            0:       return 48;
            1:       return 58;
            default: return 59;
        endcase
    endfunction

    function automatic int forced_slot(input int pos);
        int s;
        s = 0;
        for (int k = 0; k < N_FORCED; k++)
            if (forced_pos(k) == pos) s = k;
        return s;
    endfunction

    function automatic bit_src_e classify(input int pos);
        if (pos >= TXN_FIRST && pos <= TXN_LAST)
            return SRC_TXN;
        for (int k = 0; k < N_FORCED; k++)
            if (forced_pos(k) == pos) return SRC_FORCED;
        if (pos == 3 || (pos >= 33 && pos <= 36) ||
            (pos >= 42 && pos <= 47) || pos == 51)
            return SRC_CURRENT;
        return SRC_SAVED;
    endfunction

    function automatic logic [XLEN-1:0] src_mask(input bit_src_e which);
        logic [XLEN-1:0] m;
        m = '0;
        for (int p = 0; p < XLEN; p++)
            if (classify(p) == which) m[lsb_idx(p)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rfi_txn_guard.sv
module rfi_txn_guard
    import rfi_pkg::*;
#(
    parameter int               W          = TXN_W,
    parameter logic [W-1:0]     HOLD_CUR   = TXN_HOLD_CUR,
    parameter logic [W-1:0]     HOLD_SAVED = TXN_HOLD_SAVED
) (
    input  logic [W-1:0] cur_fld_i,
    input  logic [W-1:0] saved_fld_i,
    output logic [W-1:0] new_fld_o
);

    logic keep_cur;

    always_comb begin
        keep_cur  = (cur_fld_i == HOLD_CUR) && (saved_fld_i == HOLD_SAVED);
        new_fld_o = keep_cur ? cur_fld_i : saved_fld_i;
    end

endmodule

// File: rtl/rfi_enable_force.sv
module rfi_enable_force
    import rfi_pkg::*;
#(
    parameter int N = N_FORCED
) (
    input  logic [XLEN-1:0] saved_i,
    output logic [N-1:0]    en_o
);

    localparam int PROB_L = lsb_idx(PROB_POS);

    for (genvar k = 0; k < N; k++) begin : g_force
        localparam int POS_L = lsb_idx(forced_pos(k));
        assign en_o[k] = saved_i[POS_L] | saved_i[PROB_L];
    end

endmodule

// File: rtl/rfi_state_merge.sv
module rfi_state_merge
    import rfi_pkg::*;
(
    input  logic [XLEN-1:0]     cur_i,
    input  logic [XLEN-1:0]     saved_i,
    input  logic [TXN_W-1:0]    txn_fld_i,
    input  logic [N_FORCED-1:0] forced_i,
    output logic [XLEN-1:0]     state_o
);

    localparam logic [XLEN-1:0] KEEP_M = src_mask(SRC_CURRENT);
    localparam logic [XLEN-1:0] COPY_M = src_mask(SRC_SAVED);

    logic [XLEN-1:0] overlay;

    for (genvar p = 0; p < XLEN; p++) begin : g_bit
        localparam bit_src_e SRC = classify(p);
        localparam int       L   = lsb_idx(p);
        if (SRC == SRC_TXN) begin : g_txn
            assign overlay[L] = txn_fld_i[TXN_LAST - p];
        end else if (SRC == SRC_FORCED) begin : g_frc
            assign overlay[L] = forced_i[forced_slot(p)];
        end else begin : g_none
            assign overlay[L] = 1'b0;
        end
    end

    assign state_o = (cur_i & KEEP_M) | (saved_i & COPY_M) | overlay;

endmodule

// File: rtl/rfi_pc_align.sv
module rfi_pc_align
    import rfi_pkg::*;
#(
    parameter int ALIGN = 2
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_o
);

    localparam logic [XLEN-1:0] LOW_M = (XLEN'(1) << ALIGN) - XLEN'(1);

    assign pc_o = pc_i & ~LOW_M;

endmodule

// File: rtl/rfi_restorer.sv
module rfi_restorer
    import rfi_pkg::*;
#(
    parameter int PC_ALIGN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [63:0]     cur_state_i,
    input  logic [63:0]     saved_state_i,
    input  logic [63:0]     saved_pc_i,
    output logic            done_o,
    output logic [63:0]     new_state_o,
    output logic [63:0]     next_pc_o
);

    localparam int TXN_HI = lsb_idx(TXN_FIRST);
    localparam int PROB_L = lsb_idx(PROB_POS);
    localparam int EE_L   = lsb_idx(forced_pos(0));
    localparam int IR_L   = lsb_idx(forced_pos(1));
    localparam int DR_L   = lsb_idx(forced_pos(2));

    rfi_in_t  req;
    rfi_out_t nxt;
    rfi_out_t held;
    logic     done_q;

    logic [TXN_W-1:0]    txn_new;
    logic [N_FORCED-1:0] forced;

    assign req.cur_state   = cur_state_i;
    assign req.saved_state = saved_state_i;
    assign req.saved_pc    = saved_pc_i;

    rfi_txn_guard u_txn (
        .cur_fld_i   (req.cur_state[TXN_HI -: TXN_W]),
        .saved_fld_i (req.saved_state[TXN_HI -: TXN_W]),
        .new_fld_o   (txn_new)
    );

    rfi_enable_force u_force (
        .saved_i (req.saved_state),
        .en_o    (forced)
    );

    rfi_state_merge u_merge (
        .cur_i     (req.cur_state),
        .saved_i   (req.saved_state),
        .txn_fld_i (txn_new),
        .forced_i  (forced),
        .state_o   (nxt.state)
    );

    rfi_pc_align #(.ALIGN(PC_ALIGN)) u_align (
        .pc_i (req.saved_pc),
        .pc_o (nxt.pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            held   <= '0;
        end else begin
            done_q <= start_i;
            if (start_i) held <= nxt;
        end
    end

    assign done_o      = done_q;
    assign new_state_o = held.state;
    assign next_pc_o   = held.pc;

    // R2: a capture always yields a done pulse next cycle
    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R2: no done pulse without a capture the cycle before
    assert_done_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i));

    // R3: outputs hold when nothing is captured
    assert_state_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !rst) |=> ($stable(new_state_o) && $stable(next_pc_o)));

    // R4: resume address is word aligned and matches the saved PC
    assert_pc_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (next_pc_o[PC_ALIGN-1:0] == '0 &&
                    next_pc_o[63:PC_ALIGN] == $past(saved_pc_i[63:PC_ALIGN])));

    // R5: guarded pattern leaves the transactional field at its current value
    assert_txn_guard_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(cur_state_i[TXN_HI -: TXN_W]) == TXN_HOLD_CUR &&
                   $past(saved_state_i[TXN_HI -: TXN_W]) == TXN_HOLD_SAVED)
        |-> new_state_o[TXN_HI -: TXN_W] == TXN_HOLD_CUR);

    // R6: problem state turns on all three enables
    assert_enable_force_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(saved_state_i[PROB_L]))
        |-> (new_state_o[EE_L] && new_state_o[IR_L] && new_state_o[DR_L]));

endmodule

// File: tb/rfi_restorer_bench.sv
`timescale 1ns/1ps
module rfi_restorer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [63:0] cur_state_i, saved_state_i, saved_pc_i;
    logic        done_o;
    logic [63:0] new_state_o, next_pc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    rfi_restorer u_rfi_restorer (
        .clk(clk), .rst(rst), .start_i(start_i),
        .cur_state_i(cur_state_i), .saved_state_i(saved_state_i),
        .saved_pc_i(saved_pc_i), .done_o(done_o),
        .new_state_o(new_state_o), .next_pc_o(next_pc_o)
    );

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // expected restored state, positions counted MSB first
    function automatic logic [63:0] model(input logic [63:0] cur, input logic [63:0] sav);
        logic [63:0] r;
        r = cur;
        for (int m = 0; m < 64; m++) begin
            if (m <= 2 || (m >= 4 && m <= 28) || m == 32 || (m >= 37 && m <= 41) ||
                (m >= 49 && m <= 50) || (m >= 52 && m <= 57) || m >= 60)
                r[63-m] = sav[63-m];
        end
        if (cur[34:32] != 3'b010 || sav[34:32] != 3'b000)
            r[34:32] = sav[34:32];
        r[15] = sav[15] | sav[14];
        r[5]  = sav[5]  | sav[14];
        r[4]  = sav[4]  | sav[14];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] cur, input logic [63:0] sav,
                       input logic [63:0] pc, input string tag);
        logic [63:0] es, ep;
        es = model(cur, sav);
        ep = {pc[63:2], 2'b00};
        @(negedge clk);
        cur_state_i = cur; saved_state_i = sav; saved_pc_i = pc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cur_state_i = ~cur; saved_state_i = ~sav; saved_pc_i = ~pc;
        chk("R2 done after start", {63'b0, done_o}, 64'd1);
        chk(tag, new_state_o, es);
        chk("R4 aligned pc", next_pc_o, ep);
        @(negedge clk);
        chk("R2 done one cycle", {63'b0, done_o}, 64'd0);
        chk("R3 state held", new_state_o, es);
        chk("R3 pc held", next_pc_o, ep);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b1;
        cur_state_i = '1; saved_state_i = '1; saved_pc_i = '1;
        repeat (3) @(negedge clk);
        chk("R1 reset done", {63'b0, done_o}, 64'd0);
        chk("R1 reset state", new_state_o, 64'd0);
        chk("R1 reset pc", next_pc_o, 64'd0);
        start_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", {63'b0, done_o}, 64'd0);
        chk("R1 state after reset", new_state_o, 64'd0);

        // R5: every pairing of current and saved transactional field
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 8; s++) begin
                logic [63:0] cur, sav;
                cur = rnd(); sav = rnd();
                cur[34:32] = 3'(c); sav[34:32] = 3'(s);
                run(cur, sav, rnd(), "R5 txn field");
                chk("R5 txn field bits", {61'b0, new_state_o[34:32]},
                    {61'b0, ((c == 2 && s == 0) ? 3'(c) : 3'(s))});
            end
        end

        // R6: problem bit against each enable
        for (int v = 0; v < 16; v++) begin
            logic [63:0] sav;
            sav = rnd();
            sav[15] = v[0]; sav[5] = v[1]; sav[4] = v[2]; sav[14] = v[3];
            run(rnd(), sav, rnd(), "R6 forced enables");
            chk("R6 enable bits", {61'b0, new_state_o[15], new_state_o[5], new_state_o[4]},
                {61'b0, v[0] | v[3], v[1] | v[3], v[2] | v[3]});
        end

        // R7 R8: extreme words expose copy and keep masks
        run(64'h0, '1, 64'h3, "R7 copy from ones");
        run('1, 64'h0, 64'h0, "R8 keep from ones");
        run(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 64'h1, "R7 R8 alternating");

        // R7 R8 R4: random words
        for (int i = 0; i < 200; i++)
            run(rnd(), rnd(), rnd(), "R7 R8 random state");

        // R2: back-to-back captures
        begin
            logic [63:0] c1, s1, p1, c2, s2, p2;
            c1 = rnd(); s1 = rnd(); p1 = rnd();
            c2 = rnd(); s2 = rnd(); p2 = rnd();
            @(negedge clk);
            cur_state_i = c1; saved_state_i = s1; saved_pc_i = p1; start_i = 1'b1;
            @(negedge clk);
            cur_state_i = c2; saved_state_i = s2; saved_pc_i = p2;
            chk("R2 first of pair done", {63'b0, done_o}, 64'd1);
            chk("R2 first of pair state", new_state_o, model(c1, s1));
            @(negedge clk);
            start_i = 1'b0;
            chk("R2 second of pair done", {63'b0, done_o}, 64'd1);
            chk("R2 second of pair state", new_state_o, model(c2, s2));
            chk("R2 second of pair pc", next_pc_o, {p2[63:2], 2'b00});
            @(negedge clk);
            chk("R2 pair ends", {63'b0, done_o}, 64'd0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule